// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single burst start into the stream of column addresses that a memory burst visits. A start carries a starting column, a burst length of 2, 4 or 8 beats, and an ordering choice. From the next cycle on, the block presents one column per clock, with a valid flag and a flag that marks the final beat.

The low log2(BL) column bits walk through an aligned block. In sequential ordering they count up from the start column and wrap inside the block. In interleaved ordering they are the start column XORed with the beat index. The column bits above the block never change during a burst. A new start can arrive on any cycle, including during a burst. It drops the rest of the current burst, and the new burst's first column appears on the next cycle.

The column width is a parameter with a default of 8 bits and must be at least 4.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low, valid_o and last_o are 0.
- R2: When start_i is high at a rising edge, the next cycle shows valid_o=1 and col_o equal to the start_col_i sampled at that edge (beat 0).
- R3: bl_sel_i sampled with start_i selects the burst length: 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 give 8 beats. Without an interrupting start, valid_o stays high for exactly that many consecutive cycles.
- R4: With interleave_i=0 at start, beat k has low log2(BL) bits equal to (start low bits + k) mod BL. All higher bits equal those of the start column.
- R5: With interleave_i=1 at start, beat k has low log2(BL) bits equal to start low bits XOR k. All higher bits equal those of the start column.
- R6: last_o is high only on beat BL-1 of a burst, and only together with valid_o.
- R7: After the last beat, valid_o falls to 0 in the next cycle unless start_i was high at that edge.
- R8: A start during a burst drops that burst's remaining beats. The next cycle shows beat 0 of the new burst. Starts on consecutive cycles each produce only their beat 0.
- R9: A start sampled at the same edge that ends the last beat gives a gap-free stream: the new beat 0 follows the old last beat with valid_o held high.
- R10: While start_i is low, changes on start_col_i, bl_sel_i and interleave_i have no effect on col_o, valid_o or last_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new burst (preempts the current one) |
| start_col_i | input | COL_W | Starting column |
| bl_sel_i | input | 2 | Burst length code: 0=2, 1=4, 2 or 3=8 |
| interleave_i | input | 1 | 0 = sequential ordering, 1 = interleaved ordering |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Current beat is the final beat of the burst |

## Verification
The assertions check properties that hold on every cycle:
- last_o is qualified by valid_o.
- A start produces beat 0 at the start column.
- The beat index steps by one.
- The burst ends after its last beat.
- The column bits above the wrap block stay fixed during a burst.

The exact wrap order of each mode and the beat count of each length code can only be shown by the scoreboard scenarios. The same holds for preemption partway through a burst, starts on consecutive cycles, gap-free chaining, and input changes that must be ignored.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned BEAT_W = 3;  // up to 8 beats

  typedef enum logic [1:0] {
    BLEN_2  = 2'd0,
    BLEN_4  = 2'd1,
    BLEN_8  = 2'd2,
    BLEN_8A = 2'd3
  } blen_e;

  function automatic logic [BEAT_W-1:0] blen_mask(input logic [1:0] code);
    case (blen_e'(code))
      BLEN_2:  return 3'b001;
      BLEN_4:  return 3'b011;
      default: return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        bl_sel_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic [BEAT_W-1:0] mask_o,
  output logic              valid_o,
  output logic              last_o
);
  logic [BEAT_W-1:0] beat_q, mask_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= '0;
      mask_q  <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      beat_q  <= '0;
      mask_q  <= blen_mask(bl_sel_i);
      valid_q <= 1'b1;
    end else if (valid_q) begin
      if (beat_q == mask_q) valid_q <= 1'b0;
      else                  beat_q  <= beat_q + 1'b1;
    end
  end

  assign beat_o  = beat_q;
  assign mask_o  = mask_q;
  assign valid_o = valid_q;
  assign last_o  = valid_q && (beat_q == mask_q);

  p_last_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  p_start_beat0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && beat_o == '0));
  p_beat_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i) |=> (valid_o && beat_o == $past(beat_o) + 1'b1));
  p_end_after_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [BEAT_W-1:0] mask_i,
  input  logic              interleave_i,
  output logic [COL_W-1:0]  col_o
);
  logic [BEAT_W-1:0] seq_low;
  assign seq_low = base_i[BEAT_W-1:0] + beat_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < BEAT_W) begin : g_low
      logic off;
      assign off      = interleave_i ? (base_i[i] ^ beat_i[i]) : seq_low[i];
      assign col_o[i] = mask_i[i] ? off : base_i[i];
    end else begin : g_high
      assign col_o[i] = base_i[i];
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       bl_sel_i,
  input  logic             interleave_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0]  base_q;
  logic              ilv_q;
  logic [BEAT_W-1:0] beat, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      base_q <= start_col_i;
      ilv_q  <= interleave_i;
    end
  end

  burst_beat_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .bl_sel_i(bl_sel_i),
    .beat_o  (beat),
    .mask_o  (mask),
    .valid_o (valid_o),
    .last_o  (last_o)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i      (base_q),
    .beat_i      (beat),
    .mask_i      (mask),
    .interleave_i(ilv_q),
    .col_o       (col_o)
  );

  p_beat0_col_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (col_o == $past(start_col_i)));
  p_upper_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i) |=> $stable(col_o[COL_W-1:BEAT_W]));
endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  localparam int COL_W = 8;

  typedef struct {
    logic [COL_W-1:0] col;
    logic             last;
    string            tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] scol = '0;
  logic [1:0]       bsel = '0;
  logic             ilv = 1'b0;
  logic [COL_W-1:0] col;
  logic             valid, last;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  item_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  burst_col_gen #(.COL_W(COL_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .bl_sel_i(bsel), .interleave_i(ilv), .col_o(col), .valid_o(valid), .last_o(last)
  );

  function automatic int blen(input logic [1:0] c);
    return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
      input int bl, input logic il, input int k);
    int lo;
    lo = il ? ((s % bl) ^ k) : (((s % bl) + k) % bl);
    return COL_W'((s / bl) * bl + lo);
  endfunction

  // driver: start sampled at next rising edge; expected beats replace the queue
  task automatic issue(input logic [COL_W-1:0] s, input logic [1:0] c,
                       input logic il, input string tag);
    @(negedge clk); #1;
    start = 1'b1; scol = s; bsel = c; ilv = il;
    q.delete();
    for (int k = 0; k < blen(c); k++)
      q.push_back('{exp_col(s, blen(c), il, k), (k == blen(c) - 1), tag});
  endtask

  task automatic idle(input int n, input bit scramble);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      start = 1'b0;
      if (scramble) begin
        scol = scol + 8'h5B; bsel = bsel + 2'd1; ilv = ~ilv;
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (valid) begin
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R7: valid_o=1 with no beat expected (col %h)", col);
        end else begin
          item_t e;
          e = q.pop_front();
          if (col !== e.col || last !== e.last) begin
            errors++;
            $display("FAIL %s: col=%h last=%b expected col=%h last=%b",
                     e.tag, col, last, e.col, e.last);
          end
        end
      end else begin
        if (q.size() != 0) begin
          errors++;
          $display("FAIL R3: valid_o=0 expected 1 (col %h pending)", q[0].col);
        end
        if (last !== 1'b0) begin
          errors++;
          $display("FAIL R6: last_o=%b without valid, expected 0", last);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid !== 1'b0 || last !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%b last=%b expected 0 0", valid, last);
    end
    rst_n = 1'b1;
    @(negedge clk);
    running = 1'b1;
    idle(2, 1'b0);
    // R4 sequential BL4: 15 16 17 14
    issue(8'h15, 2'd1, 1'b0, "R4");
    idle(6, 1'b0);
    // R5 interleaved BL8: 2B 2A 29 28 2F 2E 2D 2C
    issue(8'h2B, 2'd2, 1'b1, "R5");
    idle(10, 1'b0);
    // R3 BL2 at top of range, wraps within block: FF FE
    issue(8'hFF, 2'd0, 1'b0, "R3");
    idle(4, 1'b0);
    // R3 code 3 aliases to 8 beats, sequential from 0x46
    issue(8'h46, 2'd3, 1'b0, "R3");
    idle(10, 1'b0);
    // R5 interleaved BL4
    issue(8'hC2, 2'd1, 1'b1, "R5");
    idle(6, 1'b0);
    // R8 preempt mid burst
    issue(8'h80, 2'd2, 1'b0, "R8");
    idle(2, 1'b0);
    issue(8'h3D, 2'd1, 1'b1, "R8");
    idle(6, 1'b0);
    // R8 starts on consecutive cycles
    issue(8'h10, 2'd2, 1'b0, "R8");
    issue(8'h21, 2'd1, 1'b1, "R8");
    issue(8'h37, 2'd0, 1'b0, "R8");
    idle(4, 1'b0);
    // R9 gap-free chaining
    issue(8'h52, 2'd0, 1'b0, "R9");
    idle(1, 1'b0);
    issue(8'h63, 2'd1, 1'b0, "R9");
    idle(3, 1'b0);
    issue(8'h74, 2'd0, 1'b1, "R9");
    idle(4, 1'b0);
    // R10 inputs ignored without start
    issue(8'h9A, 2'd2, 1'b0, "R10");
    idle(12, 1'b1);
    idle(3, 1'b0);
    running = 1'b0;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d beats undelivered, expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule